// File: doc/BRIEF.md
# Auxiliary Power and System-Control Register Block

This block holds a small set of memory-mapped control registers for board-level housekeeping: an 8-bit configuration register, an 8-bit diagnostic register, an 8-bit modem-control register, two 8-bit auxiliary registers, a 16-bit LED register and a 32-bit system-control register. Each region has its own select strobe on a simple register bus. An access size code says whether the access is a byte, a halfword or a word. An access whose size does not match the width of its region has no effect. Read data is registered and appears on the cycle after the strobe.

The block raises a power-fail interrupt when a supply monitor reports a failure and the interrupt is enabled. Two flops synchronise the power-failing input. A change on the synchronised level is then applied to a latch, which is a two-state machine with states `PF_CLEAR` and `PF_LATCHED`. The transitions are these. From `PF_CLEAR` to `PF_LATCHED` on a change to an asserted level while enable bit 3 of the configuration register is set, unless a latch-clear write comes in the same cycle. From `PF_LATCHED` to `PF_CLEAR` on a latch-clear write, or on a level change that does not qualify. Both states go to `PF_CLEAR` on reset. Writes to the auxiliary registers can also produce a terminal-count pulse toward a floppy controller and a shutdown request. A write to the system-control register can produce a system-reset request. Each of these outputs is a pulse of one cycle.

Top module: `aux_sysctl_regs`

## Requirements
- R1: `pf_irq` is high exactly when the power-fail latch is set and configuration bit 3 is 1. A configuration write changes `pf_irq` on the same clock edge that stores the new value, and the latch itself is left unchanged.
- R2: A change of `pwr_failing_in` reaches the latch at the third rising edge after it. The latch is then set if the new level is high and configuration bit 3 is 1, and is cleared otherwise.
- R3: A byte write to aux2 keeps only data bit 0 (power-off) and data bit 1 (latch clear). When bit 1 is set the latch is cleared, and this clear takes priority over a latch update in the same cycle. An aux2 read returns the latch in bit 5, power-off in bit 0 and zeros in all other bits.
- R4: A byte write to aux2 with data bit 0 set gives a one-cycle `shutdown_req` pulse on the next cycle.
- R5: A byte write to aux1 with data bit 1 set gives a one-cycle `tc_pulse` on the next cycle. Aux1 stores the written byte with bit 1 forced to 0.
- R6: Reset clears configuration, modem control, aux1, aux2 and the latch to 0. Reset does not change the diagnostic, LED and system-control registers.
- R7: A word write to system-control at offset 0 with data bit 0 set loads the value 0x02 and gives a one-cycle `sysreset_req` pulse. A write at any other offset, or with bit 0 clear, changes nothing.
- R8: `rdata` shows the selected register on the cycle after a read strobe and is 0 on every other cycle. An LED or system-control read at a nonzero offset returns 0.
- R9: The size codes are 0 for a byte, 1 for a halfword and 2 for a word. A write whose size does not match its region is ignored, and a read whose size does not match returns 0.
- R10: The configuration, diagnostic and modem registers store all 8 written bits and read them back unchanged. These byte regions ignore `addr_ofs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | 1 | Configuration register select |
| diag_sel | input | 1 | Diagnostic register select |
| mdm_sel | input | 1 | Modem-control register select |
| aux1_sel | input | 1 | Aux1 register select |
| aux2_sel | input | 1 | Aux2 register select |
| led_sel | input | 1 | LED register select |
| sctl_sel | input | 1 | System-control register select |
| wr_en | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| addr_ofs | input | 2 | Byte offset within the region |
| wdata | input | 32 | Write data |
| pwr_failing_in | input | 1 | Asynchronous power-failing indication |
| rdata | output | 32 | Registered read data |
| pf_irq | output | 1 | Power-fail interrupt |
| tc_pulse | output | 1 | Terminal-count pulse toward the floppy controller |
| shutdown_req | output | 1 | Shutdown request pulse |
| sysreset_req | output | 1 | System-reset request pulse |

## Verification
The checker checks on every cycle that each request pulse (`tc_pulse`, `shutdown_req` and `sysreset_req`) is traced back to a qualifying write on the cycle before it. It also checks that a latch-clear write leaves `pf_irq` low on the next cycle, that `rdata` is 0 whenever no read came before it, and that the interrupt and the pulses are low when reset ends.

Some behaviours can only be shown by the bench's scenarios, because they depend on state built up over many cycles:
- the three-edge latency of the synchroniser;
- the latch gating by the enable bit;
- the clear-over-update priority, hit on exactly the edge where a level change lands;
- which registers keep their contents through reset;
- size and offset filtering, seen through later reads.

// File: rtl/aux_regs_pkg.sv
package aux_regs_pkg;
    localparam int BYTE_W      = 8;
    localparam int PF_EN_BIT   = 3;
    localparam int TC_BIT      = 1;
    localparam int PWROFF_BIT  = 0;
    localparam int PFCLR_BIT   = 1;
    localparam int PF_FLAG_BIT = 5;
    localparam int SYSRST_BIT  = 0;
    localparam logic [BYTE_W-1:0] RSTSTAT_VAL = 8'h02;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic {
        PF_CLEAR   = 1'b0,
        PF_LATCHED = 1'b1
    } pf_state_e;
endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic changed
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], async_in};
        end
    end

    assign level   = chain_q[STAGES-1];
    assign changed = chain_q[STAGES-1] ^ chain_q[STAGES];
endmodule

// File: rtl/pf_latch_fsm.sv
module pf_latch_fsm
    import aux_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_changed,
    input  logic lvl_high,
    input  logic irq_en,
    input  logic clr_wr,
    output logic latched
);
    pf_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PF_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PF_CLEAR: begin
                if (lvl_changed && lvl_high && irq_en && !clr_wr) begin
                    state_d = PF_LATCHED;
                end
            end
            PF_LATCHED: begin
                if (clr_wr || (lvl_changed && !(lvl_high && irq_en))) begin
                    state_d = PF_CLEAR;
                end
            end
            default: state_d = PF_CLEAR;
        endcase
    end

    assign latched = (state_q == PF_LATCHED);
endmodule

// File: rtl/ctrl_reg_file.sv
module ctrl_reg_file
    import aux_regs_pkg::*;
#(
    parameter int LED_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_cfg,
    input  logic              we_diag,
    input  logic              we_mdm,
    input  logic              we_aux1,
    input  logic              we_aux2,
    input  logic              we_led,
    input  logic              we_sctl,
    input  logic [LED_W-1:0]  wdata,
    output logic [BYTE_W-1:0] cfg_q,
    output logic [BYTE_W-1:0] diag_q,
    output logic [BYTE_W-1:0] mdm_q,
    output logic [BYTE_W-1:0] aux1_q,
    output logic              pwroff_q,
    output logic [LED_W-1:0]  led_q,
    output logic [BYTE_W-1:0] sctl_q,
    output logic              tc_q,
    output logic              sd_q,
    output logic              sr_q
);
    localparam logic [BYTE_W-1:0] TC_MASK = BYTE_W'(1) << TC_BIT;

    // Registers cleared by reset, plus the request pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            mdm_q    <= '0;
            aux1_q   <= '0;
            pwroff_q <= 1'b0;
            tc_q     <= 1'b0;
            sd_q     <= 1'b0;
            sr_q     <= 1'b0;
        end else begin
            tc_q <= we_aux1 && wdata[TC_BIT];
            sd_q <= we_aux2 && wdata[PWROFF_BIT];
            sr_q <= we_sctl && wdata[SYSRST_BIT];
            if (we_cfg)  cfg_q    <= wdata[BYTE_W-1:0];
            if (we_mdm)  mdm_q    <= wdata[BYTE_W-1:0];
            if (we_aux1) aux1_q   <= wdata[BYTE_W-1:0] & ~TC_MASK;
            if (we_aux2) pwroff_q <= wdata[PWROFF_BIT];
        end
    end

    // Registers that keep their contents through reset
    always_ff @(posedge clk) begin
        if (we_diag) diag_q <= wdata[BYTE_W-1:0];
        if (we_led)  led_q  <= wdata;
        if (we_sctl && wdata[SYSRST_BIT]) sctl_q <= RSTSTAT_VAL;
    end
endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
    import aux_regs_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int LED_W       = 16,
    parameter int OFS_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sel,
    input  logic              diag_sel,
    input  logic              mdm_sel,
    input  logic              aux1_sel,
    input  logic              aux2_sel,
    input  logic              led_sel,
    input  logic              sctl_sel,
    input  logic              wr_en,
    input  logic [1:0]        acc_size,
    input  logic [OFS_W-1:0]  addr_ofs,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pwr_failing_in,
    output logic [DATA_W-1:0] rdata,
    output logic              pf_irq,
    output logic              tc_pulse,
    output logic              shutdown_req,
    output logic              sysreset_req
);
    logic byte_ok, led_ok, sctl_ok, rd_en;
    logic we_cfg, we_diag, we_mdm, we_aux1, we_aux2, we_led, we_sctl;
    logic [BYTE_W-1:0] cfg_q, diag_q, mdm_q, aux1_q, sctl_q, aux2_view;
    logic [LED_W-1:0]  led_q;
    logic pwroff_q, latched, lvl, lvl_chg;
    logic [DATA_W-1:0] rdata_d, rdata_q;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DATA_W-1:LED_W];

    // Size and offset qualification per region
    assign byte_ok = (acc_size == SZ_BYTE);
    assign led_ok  = (acc_size == SZ_HALF) && (addr_ofs == '0);
    assign sctl_ok = (acc_size == SZ_WORD) && (addr_ofs == '0);
    assign rd_en   = !wr_en;

    assign we_cfg  = cfg_sel  && wr_en && byte_ok;
    assign we_diag = diag_sel && wr_en && byte_ok;
    assign we_mdm  = mdm_sel  && wr_en && byte_ok;
    assign we_aux1 = aux1_sel && wr_en && byte_ok;
    assign we_aux2 = aux2_sel && wr_en && byte_ok;
    assign we_led  = led_sel  && wr_en && led_ok;
    assign we_sctl = sctl_sel && wr_en && sctl_ok;

    pf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pwr_failing_in),
        .level    (lvl),
        .changed  (lvl_chg)
    );

    pf_latch_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl_changed (lvl_chg),
        .lvl_high    (lvl),
        .irq_en      (cfg_q[PF_EN_BIT]),
        .clr_wr      (we_aux2 && wdata[PFCLR_BIT]),
        .latched     (latched)
    );

    ctrl_reg_file #(.LED_W(LED_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_cfg   (we_cfg),
        .we_diag  (we_diag),
        .we_mdm   (we_mdm),
        .we_aux1  (we_aux1),
        .we_aux2  (we_aux2),
        .we_led   (we_led),
        .we_sctl  (we_sctl),
        .wdata    (wdata[LED_W-1:0]),
        .cfg_q    (cfg_q),
        .diag_q   (diag_q),
        .mdm_q    (mdm_q),
        .aux1_q   (aux1_q),
        .pwroff_q (pwroff_q),
        .led_q    (led_q),
        .sctl_q   (sctl_q),
        .tc_q     (tc_pulse),
        .sd_q     (shutdown_req),
        .sr_q     (sysreset_req)
    );

    always_comb begin
        aux2_view              = '0;
        aux2_view[PF_FLAG_BIT] = latched;
        aux2_view[PWROFF_BIT]  = pwroff_q;
    end

    // Read multiplexer
    always_comb begin
        rdata_d = '0;
        if (rd_en) begin
            if (cfg_sel  && byte_ok) rdata_d = rdata_d | DATA_W'(cfg_q);
            if (diag_sel && byte_ok) rdata_d = rdata_d | DATA_W'(diag_q);
            if (mdm_sel  && byte_ok) rdata_d = rdata_d | DATA_W'(mdm_q);
            if (aux1_sel && byte_ok) rdata_d = rdata_d | DATA_W'(aux1_q);
            if (aux2_sel && byte_ok) rdata_d = rdata_d | DATA_W'(aux2_view);
            if (led_sel  && led_ok)  rdata_d = rdata_d | DATA_W'(led_q);
            if (sctl_sel && sctl_ok) rdata_d = rdata_d | DATA_W'(sctl_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata  = rdata_q;
    assign pf_irq = latched && cfg_q[PF_EN_BIT];
endmodule

// File: rtl/aux_regs_chk.sv
module aux_regs_chk
    import aux_regs_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_sel,
    input logic        diag_sel,
    input logic        mdm_sel,
    input logic        aux1_sel,
    input logic        aux2_sel,
    input logic        led_sel,
    input logic        sctl_sel,
    input logic        wr_en,
    input logic [1:0]  acc_size,
    input logic [1:0]  addr_ofs,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        pf_irq,
    input logic        tc_pulse,
    input logic        shutdown_req,
    input logic        sysreset_req
);
    logic any_rd;
    assign any_rd = !wr_en && (cfg_sel || diag_sel || mdm_sel || aux1_sel ||
                               aux2_sel || led_sel || sctl_sel);

    p_tc_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> $past(aux1_sel && wr_en && acc_size == SZ_BYTE && wdata[TC_BIT]));

    p_sd_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(aux2_sel && wr_en && acc_size == SZ_BYTE && wdata[PWROFF_BIT]));

    p_sr_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sysreset_req |-> $past(sctl_sel && wr_en && acc_size == SZ_WORD &&
                               addr_ofs == 2'd0 && wdata[SYSRST_BIT]));

    p_clr_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(aux2_sel && wr_en && acc_size == SZ_BYTE && wdata[PFCLR_BIT]) |-> !pf_irq);

    p_rd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(any_rd) |-> (rdata == 32'd0));

    p_reset_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!pf_irq && !tc_pulse && !shutdown_req && !sysreset_req));
endmodule

bind aux_sysctl_regs aux_regs_chk u_chk (.*);

// File: tb/aux_sysctl_regs_tb.sv
module aux_sysctl_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sel = 0, diag_sel = 0, mdm_sel = 0, aux1_sel = 0;
    logic        aux2_sel = 0, led_sel = 0, sctl_sel = 0;
    logic        wr_en = 0;
    logic [1:0]  acc_size = 0;
    logic [1:0]  addr_ofs = 0;
    logic [31:0] wdata = 0;
    logic        pwr_failing_in = 0;
    logic [31:0] rdata;
    logic        pf_irq, tc_pulse, shutdown_req, sysreset_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    aux_sysctl_regs u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_sel(cfg_sel), .diag_sel(diag_sel), .mdm_sel(mdm_sel),
        .aux1_sel(aux1_sel), .aux2_sel(aux2_sel), .led_sel(led_sel),
        .sctl_sel(sctl_sel), .wr_en(wr_en), .acc_size(acc_size),
        .addr_ofs(addr_ofs), .wdata(wdata), .pwr_failing_in(pwr_failing_in),
        .rdata(rdata), .pf_irq(pf_irq), .tc_pulse(tc_pulse),
        .shutdown_req(shutdown_req), .sysreset_req(sysreset_req)
    );

    // Behavioural reference model, advanced on every rising edge
    logic [7:0]  m_cfg = 0, m_diag = 0, m_mdm = 0, m_aux1 = 0, m_sctl = 0;
    logic [15:0] m_led = 0;
    logic        m_pwroff = 0, m_pf = 0;
    logic        m_tc = 0, m_sd = 0, m_sr = 0;
    logic [31:0] m_rd = 0;
    bit          syn[3] = '{0, 0, 0};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 0; m_mdm = 0; m_aux1 = 0; m_pwroff = 0; m_pf = 0;
            m_tc = 0; m_sd = 0; m_sr = 0; m_rd = 0;
            syn = '{0, 0, 0};
        end else begin
            logic [31:0] rv;
            bit bsz;
            bsz = (acc_size == 2'd0);
            rv = 0;
            if (!wr_en) begin
                if (cfg_sel  && bsz) rv = rv | {24'd0, m_cfg};
                if (diag_sel && bsz) rv = rv | {24'd0, m_diag};
                if (mdm_sel  && bsz) rv = rv | {24'd0, m_mdm};
                if (aux1_sel && bsz) rv = rv | {24'd0, m_aux1};
                if (aux2_sel && bsz) rv = rv | {26'd0, m_pf, 4'd0, m_pwroff};
                if (led_sel && acc_size == 2'd1 && addr_ofs == 0) rv = rv | {16'd0, m_led};
                if (sctl_sel && acc_size == 2'd2 && addr_ofs == 0) rv = rv | {24'd0, m_sctl};
            end
            m_tc = 0; m_sd = 0; m_sr = 0;
            if (syn[1] != syn[2]) m_pf = syn[1] && m_cfg[3];
            if (wr_en) begin
                if (aux2_sel && bsz) begin
                    m_pwroff = wdata[0];
                    m_sd = wdata[0];
                    if (wdata[1]) m_pf = 0;
                end
                if (aux1_sel && bsz) begin
                    m_aux1 = wdata[7:0] & 8'hFD;
                    m_tc = wdata[1];
                end
                if (cfg_sel && bsz)  m_cfg  = wdata[7:0];
                if (diag_sel && bsz) m_diag = wdata[7:0];
                if (mdm_sel && bsz)  m_mdm  = wdata[7:0];
                if (led_sel && acc_size == 2'd1 && addr_ofs == 0) m_led = wdata[15:0];
                if (sctl_sel && acc_size == 2'd2 && addr_ofs == 0 && wdata[0]) begin
                    m_sctl = 8'h02;
                    m_sr = 1;
                end
            end
            syn[2] = syn[1]; syn[1] = syn[0]; syn[0] = pwr_failing_in;
            m_rd = rv;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        chk({31'd0, pf_irq},       {31'd0, m_pf && m_cfg[3]}, "R1 pf_irq");
        chk({31'd0, tc_pulse},     {31'd0, m_tc},             "R5 tc_pulse");
        chk({31'd0, shutdown_req}, {31'd0, m_sd},             "R4 shutdown_req");
        chk({31'd0, sysreset_req}, {31'd0, m_sr},             "R7 sysreset_req");
        chk(rdata,                 m_rd,                      "R8 rdata");
    endtask

    task automatic idle();
        {cfg_sel, diag_sel, mdm_sel, aux1_sel, aux2_sel, led_sel, sctl_sel} = 7'd0;
        wr_en = 0; acc_size = 0; addr_ofs = 0; wdata = 0;
    endtask

    task automatic drive(input int region, input logic [1:0] sz, input logic [1:0] ofs,
                         input logic wr, input logic [31:0] d);
        idle();
        case (region)
            0: cfg_sel = 1;
            1: diag_sel = 1;
            2: mdm_sel = 1;
            3: aux1_sel = 1;
            4: aux2_sel = 1;
            5: led_sel = 1;
            default: sctl_sel = 1;
        endcase
        wr_en = wr; acc_size = sz; addr_ofs = ofs; wdata = d;
    endtask

    task automatic wr(input int region, input logic [1:0] sz, input logic [1:0] ofs,
                      input logic [31:0] d);
        drive(region, sz, ofs, 1'b1, d);
        step();
        idle();
    endtask

    task automatic rd(input int region, input logic [1:0] sz, input logic [1:0] ofs,
                      input logic [31:0] exp, input string tag);
        drive(region, sz, ofs, 1'b0, 32'd0);
        step();
        chk(rdata, exp, tag);
        idle();
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1;
        chk({31'd0, pf_irq}, 32'd0, "R6 irq low out of reset");
        // Retained registers get known contents
        wr(1, 2'd0, 2'd0, 32'hA5);
        wr(5, 2'd1, 2'd0, 32'h1234);
        wr(6, 2'd2, 2'd1, 32'h1);           // R7 ignored: nonzero offset
        chk({31'd0, sysreset_req}, 32'd0, "R7 no request at offset 1");
        wr(6, 2'd2, 2'd0, 32'h1);
        chk({31'd0, sysreset_req}, 32'd1, "R7 request pulse");
        step();
        chk({31'd0, sysreset_req}, 32'd0, "R7 pulse lasts one cycle");
        rd(0, 2'd0, 2'd0, 32'h0, "R6 config after reset");
        rd(4, 2'd0, 2'd0, 32'h0, "R6 aux2 after reset");
        // Plain storage
        wr(0, 2'd0, 2'd0, 32'h5A);
        wr(2, 2'd0, 2'd2, 32'h3C);
        rd(0, 2'd0, 2'd1, 32'h5A, "R10 config readback");
        rd(2, 2'd0, 2'd3, 32'h3C, "R10 modem readback any offset");
        // Power-fail latch with enable set
        pwr_failing_in = 1;
        step(); step();
        chk({31'd0, pf_irq}, 32'd0, "R2 not yet after two edges");
        step();
        chk({31'd0, pf_irq}, 32'd1, "R2 latched at third edge");
        rd(4, 2'd0, 2'd0, 32'h20, "R3 aux2 shows latch");
        wr(0, 2'd0, 2'd0, 32'h00);
        chk({31'd0, pf_irq}, 32'd0, "R1 irq masked by config");
        wr(0, 2'd0, 2'd0, 32'h08);
        chk({31'd0, pf_irq}, 32'd1, "R1 irq back, latch kept");
        wr(4, 2'd0, 2'd0, 32'hFE);
        chk({31'd0, pf_irq}, 32'd0, "R3 clear write drops irq");
        rd(4, 2'd0, 2'd0, 32'h0, "R3 only bits 0 and 1 accepted");
        // Enable clear: a level change does not latch
        wr(0, 2'd0, 2'd0, 32'h00);
        pwr_failing_in = 0; wait_n(4);
        pwr_failing_in = 1; wait_n(4);
        wr(0, 2'd0, 2'd0, 32'h08);
        chk({31'd0, pf_irq}, 32'd0, "R2 no latch while disabled");
        pwr_failing_in = 0; wait_n(4);
        pwr_failing_in = 1; wait_n(4);
        chk({31'd0, pf_irq}, 32'd1, "R2 latch while enabled");
        pwr_failing_in = 0; wait_n(4);
        chk({31'd0, pf_irq}, 32'd0, "R2 latch follows falling level");
        pwr_failing_in = 1; wait_n(4);
        // Power-off write keeps the latch
        wr(4, 2'd0, 2'd0, 32'h01);
        chk({31'd0, shutdown_req}, 32'd1, "R4 shutdown pulse");
        rd(4, 2'd0, 2'd0, 32'h21, "R3 latch and power-off");
        // Terminal count
        wr(3, 2'd0, 2'd0, 32'hFF);
        chk({31'd0, tc_pulse}, 32'd1, "R5 tc pulse");
        rd(3, 2'd0, 2'd0, 32'hFD, "R5 tc bit not stored");
        wr(3, 2'd0, 2'd0, 32'h00);
        chk({31'd0, tc_pulse}, 32'd0, "R5 no pulse without bit 1");
        // Size and offset filtering
        wr(0, 2'd2, 2'd0, 32'h11);
        rd(0, 2'd0, 2'd0, 32'h08, "R9 word write to byte region ignored");
        rd(0, 2'd1, 2'd0, 32'h0, "R9 halfword read of byte region");
        rd(5, 2'd1, 2'd2, 32'h0, "R8 LED nonzero offset");
        rd(5, 2'd1, 2'd0, 32'h1234, "R8 LED readback");
        rd(6, 2'd2, 2'd0, 32'h02, "R7 reset status");
        rd(6, 2'd2, 2'd1, 32'h0, "R8 system-control nonzero offset");
        // Clear write lands on the edge of a latch update
        wr(4, 2'd0, 2'd0, 32'h02);
        pwr_failing_in = 0; wait_n(4);
        pwr_failing_in = 1;
        step(); step();
        wr(4, 2'd0, 2'd0, 32'h02);
        chk({31'd0, pf_irq}, 32'd0, "R3 clear wins over update");
        wait_n(3);
        // Reset in mid-run
        rst_n = 0; wait_n(2);
        rst_n = 1;
        rd(1, 2'd0, 2'd0, 32'hA5, "R6 diagnostic kept");
        rd(5, 2'd1, 2'd0, 32'h1234, "R6 LED kept");
        rd(6, 2'd2, 2'd0, 32'h02, "R6 system-control kept");
        rd(0, 2'd0, 2'd0, 32'h0, "R6 config cleared");
        rd(2, 2'd0, 2'd0, 32'h0, "R6 modem cleared");
        rd(3, 2'd0, 2'd0, 32'h0, "R6 aux1 cleared");
        wait_n(4);
        rd(4, 2'd0, 2'd0, 32'h0, "R6 aux2 cleared");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule